// File: doc/BRIEF.md
# Host Port Register Access Controller

This block is a slave port that lets an external host processor read and write a small local memory through three registers: a control word, an address register and a data register. On every host cycle the block decodes a 2-bit access code and a read/write line. It captures both at the proper strobe edge and then either touches a register directly or performs one memory transaction through the data register.

All host pins are brought into the local clock domain through two-flop synchronizers. The block forms an internal data strobe from chip select and two data-strobe pins. The access code and direction are taken at the falling edge of an optional address strobe when the host drives one, and otherwise at the falling edge of the internal data strobe. Two address pointers, one for reads and one for writes, sit behind the address register. A data access can advance its pointer by one after the transfer. A ready output tells the host when a data access has finished.

Top module: `hostport_ctrl`

## Requirements
- R1: Access code 2'b00 targets the control word. A write cycle loads it from the host data, and a read cycle returns it on the read data output.
- R2: Access code 2'b10 targets the address register. A write loads both the read pointer and the write pointer with the low log2(DEPTH) bits of the host data. A read returns the read pointer, zero-extended.
- R3: Access code 2'b01 is a data access with post-increment. A read returns the memory word at the read pointer and then adds 1 to the read pointer. A write stores the host data at the write pointer and then adds 1 to the write pointer.
- R4: Access code 2'b11 is a data access that performs the same transfer as R3 and leaves both pointers unchanged.
- R5: Pointer arithmetic wraps modulo DEPTH, so incrementing from DEPTH-1 gives address 0.
- R6: If the active-low address strobe falls before the data strobe, the access code and direction in force at that address-strobe fall define the cycle. Later changes on those pins are ignored.
- R7: If the address strobe stays high, the access code and direction are taken when the internal data strobe becomes active.
- R8: The internal data strobe is active only when chip select is low and exactly one of the two data-strobe pins is low. Any other pin combination performs no access.
- R9: For a data access, ready goes low at the third rising clock edge after the data strobe becomes active at the pins and goes high again two edges later. Register accesses (codes 00 and 10) leave ready high.
- R10: After reset, the control word and both pointers are zero, ready is high and the read data output is zero.
- R11: Write cycles leave the read data output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_ds1_n | input | 1 | Host data strobe A, active low |
| hp_ds2_n | input | 1 | Host data strobe B, active low |
| hp_as_n | input | 1 | Optional host address strobe, active low; tie high if unused |
| hp_ctl | input | 2 | Access code (00 control, 01 data+inc, 10 address, 11 data) |
| hp_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| hp_wdata | input | DW | Host write data |
| hp_rdata | output | DW | Data returned by the last read cycle |
| hp_rdy | output | 1 | High when the port can finish a host cycle |

## Verification
The hardest case to reach is the one where the address strobe has captured one access code and the pins then change before the data strobe arrives. The cycle must still follow the earlier code. To reach it, the stimulus drops the address strobe, waits several clocks, and then inverts the access code and direction at the same moment it asserts the data strobe. A wrong sampling point therefore produces a different register, direction or pointer effect. Without the address strobe, the stimulus inverts the code shortly after the data strobe falls to show the capture point. Wrap-around is forced by loading the pointers with DEPTH-1. Stray strobe combinations are driven between real cycles and checked against the control word.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    ACC_CTRL     = 2'b00,
    ACC_DATA_INC = 2'b01,
    ACC_ADDR     = 2'b10,
    ACC_DATA_FIX = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e acc;
    logic rd;
  } cyc_t;

  // Codes with bit 0 set reach the memory array.
  function automatic logic acc_is_data(acc_e a);
    return a[0];
  endfunction

  function automatic logic acc_wants_inc(acc_e a);
    return a == ACC_DATA_INC;
  endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hp_cycle.sv
module hp_cycle
  import hp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ds1_n,
  input  logic       ds2_n,
  input  logic       as_n,
  input  logic [1:0] ctl,
  input  logic       rnw,
  output logic       start,
  output cyc_t       cyc
);
  logic stb, stb_q, as_q, as_fall;
  logic hold_v;
  cyc_t hold, cur;

  assign stb     = !cs_n && (ds1_n ^ ds2_n);
  assign as_fall = as_q && !as_n;
  assign start   = stb && !stb_q;
  assign cur     = '{acc: acc_e'(ctl), rd: rnw};
  assign cyc     = hold_v ? hold : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      as_q   <= 1'b1;
      hold_v <= 1'b0;
      hold   <= '{acc: ACC_CTRL, rd: 1'b0};
    end else begin
      stb_q <= stb;
      as_q  <= as_n;
      if (start) begin
        hold_v <= 1'b0;
      end else if (as_fall) begin
        hold_v <= 1'b1;
        hold   <= cur;
      end
    end
  end
endmodule

// File: rtl/hp_mem.sv
module hp_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[wa] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= arr[ra];
  end
endmodule

// File: rtl/hostport_ctrl.sv
module hostport_ctrl
  import hp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hp_cs_n,
  input  logic          hp_ds1_n,
  input  logic          hp_ds2_n,
  input  logic          hp_as_n,
  input  logic [1:0]    hp_ctl,
  input  logic          hp_rnw,
  input  logic [DW-1:0] hp_wdata,
  output logic [DW-1:0] hp_rdata,
  output logic          hp_rdy
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = 7 + DW;
  localparam logic [SW-1:0] SINIT = {4'b1111, {(3 + DW){1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_DONE} st_e;

  function automatic logic [AW-1:0] next_ptr(logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  logic          cs_s, ds1_s, ds2_s, as_s, rnw_s;
  logic [1:0]    ctl_s;
  logic [DW-1:0] wdata_s;

  hp_sync #(.W(SW), .INIT(SINIT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({hp_cs_n, hp_ds1_n, hp_ds2_n, hp_as_n, hp_ctl, hp_rnw, hp_wdata}),
    .q    ({cs_s, ds1_s, ds2_s, as_s, ctl_s, rnw_s, wdata_s})
  );

  logic start;
  cyc_t cyc;

  hp_cycle u_cycle (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_s),
    .ds1_n(ds1_s),
    .ds2_n(ds2_s),
    .as_n (as_s),
    .ctl  (ctl_s),
    .rnw  (rnw_s),
    .start(start),
    .cyc  (cyc)
  );

  st_e           state;
  cyc_t          cmd_q;
  logic [DW-1:0] ctrl_q, wd_q, reg_rd_q, mem_q;
  logic [AW-1:0] rptr, wptr;
  logic          rdy_q, from_mem;

  // Named internal events
  logic mem_go, mem_wr, mem_rd, mem_inc;
  assign mem_go  = (state == ST_MEM);
  assign mem_wr  = mem_go && !cmd_q.rd;
  assign mem_rd  = mem_go && cmd_q.rd;
  assign mem_inc = mem_go && acc_wants_inc(cmd_q.acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_q    <= '{acc: ACC_CTRL, rd: 1'b0};
      ctrl_q   <= '0;
      wd_q     <= '0;
      reg_rd_q <= '0;
      rptr     <= '0;
      wptr     <= '0;
      rdy_q    <= 1'b1;
      from_mem <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (acc_is_data(cyc.acc)) begin
              state <= ST_MEM;
              rdy_q <= 1'b0;
              cmd_q <= cyc;
              wd_q  <= wdata_s;
            end else if (cyc.acc == ACC_CTRL) begin
              if (cyc.rd) begin
                reg_rd_q <= ctrl_q;
                from_mem <= 1'b0;
              end else begin
                ctrl_q <= wdata_s;
              end
            end else begin
              if (cyc.rd) begin
                reg_rd_q <= DW'(rptr);
                from_mem <= 1'b0;
              end else begin
                rptr <= wdata_s[AW-1:0];
                wptr <= wdata_s[AW-1:0];
              end
            end
          end
        end
        ST_MEM: begin
          state <= ST_DONE;
          if (cmd_q.rd) from_mem <= 1'b1;
          if (mem_inc) begin
            if (cmd_q.rd) rptr <= next_ptr(rptr);
            else          wptr <= next_ptr(wptr);
          end
        end
        default: begin
          state <= ST_IDLE;
          rdy_q <= 1'b1;
        end
      endcase
    end
  end

  hp_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_wr),
    .wa   (wptr),
    .wd   (wd_q),
    .re   (mem_rd),
    .ra   (rptr),
    .q    (mem_q)
  );

  assign hp_rdata = from_mem ? mem_q : reg_rd_q;
  assign hp_rdy   = rdy_q;

endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hp_rdy,
  input logic          start,
  input logic [1:0]    start_acc,
  input logic          start_rd,
  input logic          mem_go,
  input logic          mem_rd,
  input logic          mem_inc,
  input logic [AW-1:0] rptr,
  input logic [AW-1:0] wptr,
  input logic [DW-1:0] ctrl_q
);
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && hp_rdy && start_acc == 2'b00 && !start_rd) |=> $stable(ctrl_q));

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hp_rdy && start_acc == 2'b10 && !start_rd) |=> (rptr == wptr));

  p_rd_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && mem_inc && mem_rd) |=> (rptr == AW'($past(rptr) + 1'b1)) && $stable(wptr));

  p_wr_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && mem_inc && !mem_rd) |=> (wptr == AW'($past(wptr) + 1'b1)) && $stable(rptr));

  p_no_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_go && !mem_inc) |=> $stable(rptr) && $stable(wptr));

  p_data_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hp_rdy && start_acc[0]) |=> !hp_rdy);

  p_reg_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hp_rdy && !start_acc[0]) |=> hp_rdy);

  p_rdy_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hp_rdy) |=> !hp_rdy ##1 hp_rdy);
endmodule

bind hostport_ctrl hp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hp_rdy   (hp_rdy),
  .start    (start),
  .start_acc(cyc.acc),
  .start_rd (cyc.rd),
  .mem_go   (mem_go),
  .mem_rd   (mem_rd),
  .mem_inc  (mem_inc),
  .rptr     (rptr),
  .wptr     (wptr),
  .ctrl_q   (ctrl_q)
);

// File: tb/sim_hostport_ctrl.sv
module sim_hostport_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hp_cs_n = 1'b1, hp_ds1_n = 1'b1, hp_ds2_n = 1'b1, hp_as_n = 1'b1;
  logic [1:0]    hp_ctl = 2'b00;
  logic          hp_rnw = 1'b0;
  logic [DW-1:0] hp_wdata = '0;
  logic [DW-1:0] hp_rdata;
  logic          hp_rdy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hostport_ctrl #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .hp_cs_n(hp_cs_n), .hp_ds1_n(hp_ds1_n),
    .hp_ds2_n(hp_ds2_n), .hp_as_n(hp_as_n), .hp_ctl(hp_ctl), .hp_rnw(hp_rnw),
    .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .hp_rdy(hp_rdy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state
  logic [DW-1:0] m_ctrl = '0;
  logic [DW-1:0] m_rdata = '0;
  int            m_rp = 0, m_wp = 0;
  logic [DW-1:0] m_mem [DEPTH];

  function automatic int step(int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_cycle(input logic [1:0] acc, input logic rd, input logic [DW-1:0] d,
                            input bit use_as, input bit use_ds2, input string note);
    logic [DW-1:0] exp;
    string tag;
    case (acc)
      2'b00:   tag = "R1";
      2'b10:   tag = "R2";
      2'b01:   tag = "R3";
      default: tag = "R4";
    endcase
    tag = {tag, use_as ? "+R6" : "+R7", note};
    @(negedge clk);
    hp_cs_n = 1'b0; hp_ctl = acc; hp_rnw = rd; hp_wdata = d;
    if (use_as) begin
      hp_as_n = 1'b0;
      repeat (4) @(negedge clk);
      hp_ctl = ~acc; hp_rnw = ~rd;   // pins change; captured code must win
    end
    if (use_ds2) hp_ds2_n = 1'b0; else hp_ds1_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({"R9 busy ", tag}, DW'(hp_rdy), DW'(acc[0] ? 1'b0 : 1'b1));
    if (!use_as) begin
      hp_ctl = ~acc; hp_rnw = ~rd;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({"R9 done ", tag}, DW'(hp_rdy), DW'(1'b1));
    exp = m_rdata;
    case (acc)
      2'b00: if (rd) exp = m_ctrl; else m_ctrl = d;
      2'b10: if (rd) exp = DW'(m_rp); else begin m_rp = int'(d) % DEPTH; m_wp = m_rp; end
      default: begin
        if (rd) begin
          exp = m_mem[m_rp];
          if (acc == 2'b01) m_rp = step(m_rp);
        end else begin
          m_mem[m_wp] = d;
          if (acc == 2'b01) m_wp = step(m_wp);
        end
      end
    endcase
    if (rd) begin
      m_rdata = exp;
      check({"read ", tag}, hp_rdata, m_rdata);
    end else begin
      check({"R11 ", tag}, hp_rdata, m_rdata);
    end
    hp_cs_n = 1'b1; hp_ds1_n = 1'b1; hp_ds2_n = 1'b1; hp_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Pin combinations that must not form a strobe (R8)
  task automatic stray_cycle(input int kind);
    @(negedge clk);
    hp_ctl = 2'b00; hp_rnw = 1'b0; hp_wdata = 16'hDEAD;
    case (kind)
      0: begin hp_cs_n = 1'b1; hp_ds1_n = 1'b0; end
      1: begin hp_cs_n = 1'b0; hp_ds1_n = 1'b0; hp_ds2_n = 1'b0; end
      default: begin hp_cs_n = 1'b1; hp_ds2_n = 1'b0; end
    endcase
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 rdy", DW'(hp_rdy), DW'(1'b1));
    end
    hp_cs_n = 1'b1; hp_ds1_n = 1'b1; hp_ds2_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rdy", DW'(hp_rdy), DW'(1'b1));
    check("R10 rdata", hp_rdata, '0);
    host_cycle(2'b00, 1'b1, '0, 0, 0, " R10");
    host_cycle(2'b10, 1'b1, '0, 1, 0, " R10");

    // Fill the memory through the auto-increment write path
    host_cycle(2'b10, 1'b0, '0, 0, 1, "");
    for (int i = 0; i < DEPTH; i++)
      host_cycle(2'b01, 1'b0, DW'($urandom), i % 2, i % 3 == 0, "");
    host_cycle(2'b10, 1'b1, '0, 0, 0, " R5");   // read pointer still 0

    // Wrap-around
    host_cycle(2'b10, 1'b0, DW'(DEPTH - 1), 1, 0, " R5");
    host_cycle(2'b01, 1'b0, 16'h1111, 0, 0, " R5");
    host_cycle(2'b01, 1'b0, 16'h2222, 1, 1, " R5");
    host_cycle(2'b10, 1'b0, DW'(DEPTH - 1), 0, 0, " R5");
    host_cycle(2'b01, 1'b1, '0, 0, 0, " R5");
    host_cycle(2'b01, 1'b1, '0, 1, 0, " R5");
    host_cycle(2'b10, 1'b1, '0, 0, 1, " R5");

    // Fixed-address data access
    host_cycle(2'b11, 1'b0, 16'hABCD, 1, 0, "");
    host_cycle(2'b11, 1'b1, '0, 0, 0, "");
    host_cycle(2'b10, 1'b1, '0, 1, 1, "");

    // Control word and stray strobes
    host_cycle(2'b00, 1'b0, 16'h5A5A, 0, 0, "");
    for (int k = 0; k < 3; k++) begin
      stray_cycle(k);
      host_cycle(2'b00, 1'b1, '0, 0, 0, " R8");
    end

    // Random mix
    for (int i = 0; i < 120; i++) begin
      host_cycle(2'($urandom), 1'($urandom), DW'($urandom), 1'($urandom), 1'($urandom), "");
    end
    finish_run();
  end
endmodule